// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns active-low external interrupt pins into internal request lines for an interrupt controller. Each channel brings its pin into the system clock domain through a short synchroniser chain. It then compares the current synchronised sample with the previous one to find falling and rising transitions. A falling transition asserts the channel's internal request, which is active low.

The way a request is released depends on a per-channel mode bit. With the mode bit at 0 (level mode), the request releases when the pin goes back high, and acknowledges are ignored. With the mode bit at 1 (edge mode), only an acknowledge from the controller releases it, and the pin going high changes nothing. A new falling transition always takes precedence over a release that happens in the same clock. Channels are fully independent. The channel count and synchroniser depth are parameters, with defaults of two channels and two stages.

Top module: `irq_latch`

## Requirements
- R1: While reset is asserted, and directly after it is released, every bit of `req_n` is 1 (no request).
- R2: A high-to-low change on `pin_n[i]` drives `req_n[i]` to 0. The change appears after the third rising clock edge that follows the pin change (two synchroniser stages plus the request register), and not after the second.
- R3: In level mode (`edge_mode[i]` = 0), a low-to-high change on `pin_n[i]` returns `req_n[i]` to 1 with the same three-edge latency as R2.
- R4: In edge mode (`edge_mode[i]` = 1), a low-to-high change on `pin_n[i]` leaves `req_n[i]` at 0.
- R5: In edge mode, `ack[i]` high at a rising clock edge returns `req_n[i]` to 1 after that edge.
- R6: In level mode, `ack[i]` has no effect: `req_n[i]` keeps its value.
- R7: If a new falling transition and a release condition (acknowledge or rising transition) fall on the same clock, `req_n[i]` ends up at 0.
- R8: With no transition and no valid acknowledge, `req_n[i]` holds its value, and the pins, modes and acknowledges of one channel never affect another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NCH | Asynchronous active-low interrupt pins |
| edge_mode | input | NCH | Per-channel mode: 0 level, 1 edge |
| ack | input | NCH | Per-channel acknowledge from the controller |
| req_n | output | NCH | Active-low internal request per channel |

## Verification
The stored request bit is the only state that leaves the block, and any error in it shows on `req_n` one clock after the event that set it wrong. An error in the synchroniser or the edge history shows up as a request that moves at the wrong edge or not at all. The bench therefore samples both the edge before and the edge at the expected three-edge latency. A mode mix-up shows as a request that releases on the pin in edge mode, or that follows an acknowledge in level mode, and both cases are checked within a few cycles of the stimulus.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  // Falling transition between two synchronised samples of an active-low pin
  function automatic logic fall_of(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic rise_of(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  // Next value of an active-low request bit; a fresh falling edge has priority
  function automatic logic next_req(input logic cur_n, input logic fall,
                                    input logic rise, input logic edge_md,
                                    input logic ackn);
    logic release_now;
    release_now = edge_md ? ackn : rise;
    if (fall)             return 1'b0;
    else if (release_now) return 1'b1;
    else                  return cur_n;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge.sv
module irq_edge
  import irq_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  output logic fall,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= cur;
  end

  assign fall = fall_of(prev, cur);
  assign rise = rise_of(prev, cur);
endmodule

// File: rtl/irq_req_cell.sv
module irq_req_cell
  import irq_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic rise,
  input  logic edge_md,
  input  logic ackn,
  output logic req_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_n <= 1'b1;
    else        req_n <= next_req(req_n, fall, rise, edge_md, ackn);
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int NCH       = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_n,
  input  logic [NCH-1:0] edge_mode,
  input  logic [NCH-1:0] ack,
  output logic [NCH-1:0] req_n
);
  localparam int LATENCY = SYNC_DEPTH + 1;

  // Named internal events, also observed by the bound checker
  logic [NCH-1:0] pin_s;
  logic [NCH-1:0] fall_ev;
  logic [NCH-1:0] rise_ev;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      irq_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_n[c]), .q(pin_s[c])
      );
      irq_edge u_edge (
        .clk(clk), .rst_n(rst_n), .cur(pin_s[c]),
        .fall(fall_ev[c]), .rise(rise_ev[c])
      );
      irq_req_cell u_cell (
        .clk(clk), .rst_n(rst_n), .fall(fall_ev[c]), .rise(rise_ev[c]),
        .edge_md(edge_mode[c]), .ackn(ack[c]), .req_n(req_n[c])
      );
    end
  endgenerate

  initial begin
    if (LATENCY < 3) $error("SYNC_DEPTH must be at least 2");
  end
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] edge_mode,
  input logic [NCH-1:0] ack,
  input logic [NCH-1:0] fall_ev,
  input logic [NCH-1:0] rise_ev,
  input logic [NCH-1:0] req_n
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (req_n == {NCH{1'b1}})
        else $error("request asserted during reset");
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      assert_fall_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev[c] |=> !req_n[c]);

      assert_level_rise_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode[c] && rise_ev[c] && !fall_ev[c]) |=> req_n[c]);

      assert_edge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode[c] && !ack[c] && !fall_ev[c]) |=> $stable(req_n[c]));

      assert_edge_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode[c] && ack[c] && !fall_ev[c]) |=> req_n[c]);

      assert_level_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode[c] && !rise_ev[c] && !fall_ev[c]) |=> $stable(req_n[c]));

      assert_edges_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_ev[c] && rise_ev[c]));
    end
  endgenerate
endmodule

bind irq_latch irq_latch_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .ack(ack),
  .fall_ev(fall_ev), .rise_ev(rise_ev), .req_n(req_n)
);

// File: tb/irq_latch_tb.sv
module irq_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int LAT = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_n = '1;
  logic [NCH-1:0] edge_mode = '0;
  logic [NCH-1:0] ack = '0;
  logic [NCH-1:0] req_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_latch #(.NCH(NCH), .SYNC_DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n),
    .edge_mode(edge_mode), .ack(ack), .req_n(req_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NCH-1:0] exp);
    checks++;
    if (req_n !== exp) begin
      errors++;
      $display("FAIL %s: req_n=%b expected=%b at %0t", req, req_n, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_n = '1; ack = '0;
    cycles(2);
    check("R1 during reset", 2'b11);
    rst_n = 1'b1;
    cycles(3);
    check("R1 after reset", 2'b11);
  endtask

  task automatic t_level();
    edge_mode = 2'b00;
    pin_n[0] = 1'b0;
    cycles(LAT-1);
    check("R2 not before latency", 2'b11);
    cycles(1);
    check("R2 fall asserts", 2'b10);
    cycles(4);
    check("R8 holds while low", 2'b10);
    ack[0] = 1'b1; cycles(1); ack[0] = 1'b0; cycles(1);
    check("R6 ack ignored in level", 2'b10);
    pin_n[0] = 1'b1;
    cycles(LAT-1);
    check("R3 not before latency", 2'b10);
    cycles(1);
    check("R3 rise releases", 2'b11);
    ack[0] = 1'b1; cycles(1); ack[0] = 1'b0;
    check("R6 ack idle level", 2'b11);
  endtask

  task automatic t_edge();
    edge_mode = 2'b10;
    ack[1] = 1'b1; cycles(1); ack[1] = 1'b0;
    check("R5 ack with no request", 2'b11);
    pin_n[1] = 1'b0;
    cycles(LAT);
    check("R2 edge fall asserts", 2'b01);
    pin_n[1] = 1'b1;
    cycles(LAT + 3);
    check("R4 rise ignored in edge", 2'b01);
    ack[1] = 1'b1; cycles(1); ack[1] = 1'b0;
    check("R5 ack releases", 2'b11);
  endtask

  task automatic t_collision();
    edge_mode = 2'b10;
    pin_n[1] = 1'b0; cycles(LAT);
    check("R2 collision setup", 2'b01);
    pin_n[1] = 1'b1; cycles(LAT + 1);
    pin_n[1] = 1'b0;
    cycles(LAT - 1);
    ack[1] = 1'b1;
    cycles(1);
    ack[1] = 1'b0;
    check("R7 fall beats ack", 2'b01);
    cycles(2);
    check("R7 stays asserted", 2'b01);
    ack[1] = 1'b1; cycles(1); ack[1] = 1'b0;
    check("R5 release after collision", 2'b11);
    pin_n[1] = 1'b1; cycles(LAT + 1);
    check("R4 rise after release", 2'b11);
  endtask

  task automatic t_independent();
    edge_mode = 2'b10;
    pin_n = 2'b00;
    cycles(LAT);
    check("R8 both asserted", 2'b00);
    pin_n = 2'b11;
    cycles(LAT);
    check("R8 modes differ on rise", 2'b01);
    ack = 2'b01; cycles(1); ack = 2'b00;
    check("R8 ack of ch0 leaves ch1", 2'b01);
    ack = 2'b10; cycles(1); ack = 2'b00;
    check("R8 ack of ch1 only", 2'b11);
  endtask

  initial begin
    cycles(1);
    do_reset();
    t_level();
    t_edge();
    t_collision();
    t_independent();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule